// File: doc/BRIEF.md
# Accumulator ALU with Nibble Carry

This block is the arithmetic and logic unit of a small accumulator-style processor. Each operation takes the working-register value and a second operand. The second operand is a file-register value or an immediate constant; the caller chooses which one. The block computes an 8-bit result together with carry, nibble-carry (digit carry) and zero flags. It also produces one write enable per flag, so the status register changes only the flags that the chosen operation defines.

An operation is presented with `in_valid` high, and its result appears on the registered outputs one clock later. On subtraction the carry and nibble-carry flags hold the inverse of the borrow. The two rotates pass through the carry flag. Routing the result to a destination, and the register file itself, belong to the surrounding core.

Top module: `acc_alu_core`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `out_valid`, `result`, `c_we`, `dc_we` and `z_we` are all 0.
- R2: `out_valid` is high exactly one cycle after a cycle with `in_valid` high. That cycle's result and flags appear on the outputs in the same cycle as `out_valid`.
- R3: Op code 0 (add) gives `result` = (`f_opnd` + `w_opnd`) mod 256. `c_out` is the carry out of bit 7 and `dc_out` is the carry out of bit 3. `c_we`, `dc_we` and `z_we` are all 1.
- R4: Op code 1 (subtract) gives `result` = (`f_opnd` − `w_opnd`) mod 256. `c_out` is 1 exactly when `f_opnd` ≥ `w_opnd` unsigned, meaning no borrow. `dc_out` is 1 exactly when `f_opnd[3:0]` ≥ `w_opnd[3:0]`. All three enables are 1.
- R5: Whenever `z_we` is 1, `z_out` is 1 exactly when `result` is 0.
- R6: Op codes 2, 3 and 4 give `w_opnd` AND, OR and XOR `f_opnd` respectively. Only `z_we` is 1.
- R7: Op code 5 gives the bitwise complement of `f_opnd`, and op code 6 passes `f_opnd` through unchanged. For both, only `z_we` is 1.
- R8: Op code 7 (rotate left through carry) gives `result` = {`f_opnd[6:0]`, `c_in`} and `c_out` = `f_opnd[7]`. Only `c_we` is 1.
- R9: Op code 8 (rotate right through carry) gives `result` = {`c_in`, `f_opnd[7:1]`} and `c_out` = `f_opnd[0]`. Only `c_we` is 1.
- R10: Op codes 9 to 15 are reserved. They give `result` = 0 with all three enables at 0.
- R11: A cycle with `in_valid` low leaves `out_valid` and every enable at 0 in the following cycle, and `result` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An operation is presented this cycle |
| op | input | 4 | Operation code (see R3–R10) |
| f_opnd | input | 8 | File-register or immediate operand |
| w_opnd | input | 8 | Working-register operand |
| c_in | input | 1 | Current carry flag, used by rotates |
| out_valid | output | 1 | Result and flags are valid this cycle |
| result | output | 8 | Operation result |
| c_out | output | 1 | New carry (not-borrow on subtract) |
| dc_out | output | 1 | New nibble carry (not-borrow from bit 3 on subtract) |
| z_out | output | 1 | New zero flag |
| c_we | output | 1 | Write enable for the carry flag |
| dc_we | output | 1 | Write enable for the nibble-carry flag |
| z_we | output | 1 | Write enable for the zero flag |

## Verification
The only state in the block is a single output register, so any internal fault shows at the ports in the cycle right after the operation that caused it. A wrong carry-in or an inverted operand in the shared adder shows up as an add or subtract result that is off by one, or as a borrow flag with the wrong sense. The bench targets this with equal operands, differences that cross zero, and low nibbles that match or differ. A wrong enable mask is caught by comparing all three enables on every operation: for example, a logic operation that is allowed to write the carry flag.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

    localparam int ALU_W  = 8;
    localparam int NIB_W  = ALU_W / 2;
    localparam int OP_W   = 4;

    typedef logic [ALU_W-1:0] word_t;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_AND  = 4'd2,
        OP_OR   = 4'd3,
        OP_XOR  = 4'd4,
        OP_COMF = 4'd5,
        OP_PASS = 4'd6,
        OP_RLC  = 4'd7,
        OP_RRC  = 4'd8
    } alu_op_e;

    typedef struct packed {
        logic c;
        logic dc;
        logic z;
    } flag_set_t;

    typedef struct packed {
        word_t     data;
        flag_set_t val;
        flag_set_t wen;
    } alu_out_t;

    typedef enum logic [1:0] {
        CLS_ARITH,
        CLS_LOGIC,
        CLS_ROT,
        CLS_NONE
    } op_class_e;

    function automatic op_class_e classify(logic [OP_W-1:0] code);
        op_class_e cls;
        case (code)
            OP_ADD, OP_SUB:                             cls = CLS_ARITH;
            OP_AND, OP_OR, OP_XOR, OP_COMF, OP_PASS:    cls = CLS_LOGIC;
            OP_RLC, OP_RRC:                             cls = CLS_ROT;
            default:                                    cls = CLS_NONE;
        endcase
        return cls;
    endfunction

    function automatic flag_set_t flag_mask(op_class_e cls);
        flag_set_t m;
        case (cls)
            CLS_ARITH: m = '{c: 1'b1, dc: 1'b1, z: 1'b1};
            CLS_LOGIC: m = '{c: 1'b0, dc: 1'b0, z: 1'b1};
            CLS_ROT:   m = '{c: 1'b1, dc: 1'b0, z: 1'b0};
            default:   m = '{c: 1'b0, dc: 1'b0, z: 1'b0};
        endcase
        return m;
    endfunction

    function automatic logic is_zero(word_t v);
        return (v == '0);
    endfunction

endpackage

// File: rtl/acc_alu_addsub.sv
module acc_alu_addsub
    import acc_alu_pkg::*;
(
    input  word_t a_opnd,
    input  word_t b_opnd,
    input  logic  do_sub,
    output word_t sum,
    output logic  carry,
    output logic  nib_carry
);
    // Subtraction is a - b = a + ~b + 1; the carries come out as not-borrow.
    word_t               b_eff;
    logic                cin;
    logic [ALU_W:0]      full_sum;
    logic [NIB_W:0]      low_sum;

    always_comb begin
        b_eff     = do_sub ? ~b_opnd : b_opnd;
        cin       = do_sub;
        full_sum  = {1'b0, a_opnd} + {1'b0, b_eff} + {{ALU_W{1'b0}}, cin};
        low_sum   = {1'b0, a_opnd[NIB_W-1:0]} + {1'b0, b_eff[NIB_W-1:0]}
                  + {{NIB_W{1'b0}}, cin};
        sum       = full_sum[ALU_W-1:0];
        carry     = full_sum[ALU_W];
        nib_carry = low_sum[NIB_W];
    end

endmodule

// File: rtl/acc_alu_logic.sv
module acc_alu_logic
    import acc_alu_pkg::*;
(
    input  logic [OP_W-1:0] op,
    input  word_t           f_opnd,
    input  word_t           w_opnd,
    output word_t           data
);
    always_comb begin
        case (op)
            OP_AND:  data = w_opnd & f_opnd;
            OP_OR:   data = w_opnd | f_opnd;
            OP_XOR:  data = w_opnd ^ f_opnd;
            OP_COMF: data = ~f_opnd;
            OP_PASS: data = f_opnd;
            default: data = '0;
        endcase
    end

endmodule

// File: rtl/acc_alu_rotate.sv
module acc_alu_rotate
    import acc_alu_pkg::*;
(
    input  word_t f_opnd,
    input  logic  c_in,
    input  logic  to_right,
    output word_t data,
    output logic  c_out
);
    word_t left_v;
    word_t right_v;

    for (genvar i = 0; i < ALU_W; i++) begin : g_bit
        if (i == 0) begin : g_lo
            assign left_v[i] = c_in;
        end else begin : g_lo_n
            assign left_v[i] = f_opnd[i-1];
        end
        if (i == ALU_W-1) begin : g_hi
            assign right_v[i] = c_in;
        end else begin : g_hi_n
            assign right_v[i] = f_opnd[i+1];
        end
    end

    assign data  = to_right ? right_v : left_v;
    assign c_out = to_right ? f_opnd[0] : f_opnd[ALU_W-1];

endmodule

// File: rtl/acc_alu_core.sv
module acc_alu_core
    import acc_alu_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [OP_W-1:0]     op,
    input  logic [ALU_W-1:0]    f_opnd,
    input  logic [ALU_W-1:0]    w_opnd,
    input  logic                c_in,
    output logic                out_valid,
    output logic [ALU_W-1:0]    result,
    output logic                c_out,
    output logic                dc_out,
    output logic                z_out,
    output logic                c_we,
    output logic                dc_we,
    output logic                z_we
);
    op_class_e cls;
    word_t     as_sum;
    logic      as_c;
    logic      as_dc;
    word_t     lg_data;
    word_t     rt_data;
    logic      rt_c;
    alu_out_t  nxt;
    alu_out_t  out_q;
    logic      vld_q;

    assign cls = classify(op);

    acc_alu_addsub u_addsub (
        .a_opnd    (f_opnd),
        .b_opnd    (w_opnd),
        .do_sub    (op == OP_SUB),
        .sum       (as_sum),
        .carry     (as_c),
        .nib_carry (as_dc)
    );

    acc_alu_logic u_logic (
        .op     (op),
        .f_opnd (f_opnd),
        .w_opnd (w_opnd),
        .data   (lg_data)
    );

    acc_alu_rotate u_rotate (
        .f_opnd   (f_opnd),
        .c_in     (c_in),
        .to_right (op == OP_RRC),
        .data     (rt_data),
        .c_out    (rt_c)
    );

    always_comb begin
        nxt = '0;
        case (cls)
            CLS_ARITH: begin
                nxt.data   = as_sum;
                nxt.val.c  = as_c;
                nxt.val.dc = as_dc;
            end
            CLS_LOGIC: nxt.data = lg_data;
            CLS_ROT: begin
                nxt.data  = rt_data;
                nxt.val.c = rt_c;
            end
            default: nxt.data = '0;
        endcase
        nxt.val.z = is_zero(nxt.data);
        nxt.wen   = flag_mask(cls);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
            vld_q <= 1'b0;
        end else begin
            vld_q <= in_valid;
            if (in_valid) begin
                out_q <= nxt;
            end else begin
                out_q.wen <= '0;
            end
        end
    end

    assign out_valid = vld_q;
    assign result    = out_q.data;
    assign c_out     = out_q.val.c;
    assign dc_out    = out_q.val.dc;
    assign z_out     = out_q.val.z;
    assign c_we      = out_q.wen.c;
    assign dc_we     = out_q.wen.dc;
    assign z_we      = out_q.wen.z;

endmodule

// File: rtl/acc_alu_checker.sv
module acc_alu_checker
    import acc_alu_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                in_valid,
    input logic [OP_W-1:0]     op,
    input logic [ALU_W-1:0]    f_opnd,
    input logic [ALU_W-1:0]    w_opnd,
    input logic                c_in,
    input logic                out_valid,
    input logic [ALU_W-1:0]    result,
    input logic                c_out,
    input logic                dc_out,
    input logic                z_out,
    input logic                c_we,
    input logic                dc_we,
    input logic                z_we
);
    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid));

    // R11
    idle_wen_chk: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> !(c_we || dc_we || z_we));

    // R5
    zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
        z_we |-> (z_out == (result == '0)));

    // R6
    logic_keeps_carry_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(op) >= 4'd2 && $past(op) <= 4'd6)
            |-> (!c_we && !dc_we && z_we));

    // R8
    rlc_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(op) == 4'd7)
            |-> (result == {$past(f_opnd[ALU_W-2:0]), $past(c_in)}
                 && c_out == $past(f_opnd[ALU_W-1]) && c_we && !z_we));

    // R4
    sub_borrow_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(op) == 4'd1)
            |-> (c_out == ($past(f_opnd) >= $past(w_opnd))
                 && dc_out == ($past(f_opnd[NIB_W-1:0]) >= $past(w_opnd[NIB_W-1:0]))));

endmodule

bind acc_alu_core acc_alu_checker chk_i (.*);

// File: tb/acc_alu_core_tb.sv
module acc_alu_core_tb_top;

    typedef struct {
        string      tag;
        logic [7:0] data;
        logic       c;
        logic       dc;
        logic       z;
        logic       cwe;
        logic       dcwe;
        logic       zwe;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst;
    logic       in_valid;
    logic [3:0] op;
    logic [7:0] f_opnd;
    logic [7:0] w_opnd;
    logic       c_in;
    logic       out_valid;
    logic [7:0] result;
    logic       c_out, dc_out, z_out, c_we, dc_we, z_we;

    int   n_checks = 0;
    int   n_errors = 0;
    exp_t sb_q[$];
    logic [7:0] last_data;

    always #2 clk = ~clk;

    acc_alu_core dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op(op),
        .f_opnd(f_opnd), .w_opnd(w_opnd), .c_in(c_in),
        .out_valid(out_valid), .result(result), .c_out(c_out),
        .dc_out(dc_out), .z_out(z_out), .c_we(c_we), .dc_we(dc_we), .z_we(z_we)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic exp_t model(int code, int f, int w, bit cin);
        exp_t e;
        int   d = 0;
        e.c = 0; e.dc = 0; e.z = 0; e.cwe = 0; e.dcwe = 0; e.zwe = 0;
        case (code)
            0: begin e.tag = "R3 add"; d = (f + w) % 256; e.c = (f + w) > 255;
                     e.dc = ((f % 16) + (w % 16)) > 15; e.cwe = 1; e.dcwe = 1; e.zwe = 1; end
            1: begin e.tag = "R4 sub"; d = (f - w + 256) % 256; e.c = (f >= w);
                     e.dc = ((f % 16) >= (w % 16)); e.cwe = 1; e.dcwe = 1; e.zwe = 1; end
            2: begin e.tag = "R6 and"; d = f & w; e.zwe = 1; end
            3: begin e.tag = "R6 or";  d = f | w; e.zwe = 1; end
            4: begin e.tag = "R6 xor"; d = f ^ w; e.zwe = 1; end
            5: begin e.tag = "R7 comf"; d = 255 - f; e.zwe = 1; end
            6: begin e.tag = "R7 pass"; d = f; e.zwe = 1; end
            7: begin e.tag = "R8 rlc"; d = ((f * 2) % 256) + cin; e.c = (f >= 128); e.cwe = 1; end
            8: begin e.tag = "R9 rrc"; d = (f / 2) + (cin ? 128 : 0); e.c = f % 2; e.cwe = 1; end
            default: begin e.tag = "R10 reserved"; d = 0; end
        endcase
        e.data = d[7:0];
        e.z    = (d == 0);   // R5
        return e;
    endfunction

    task automatic send(int code, int f, int w, bit cin);
        @(negedge clk);
        in_valid = 1'b1;
        op       = code[3:0];
        f_opnd   = f[7:0];
        w_opnd   = w[7:0];
        c_in     = cin;
        sb_q.push_back(model(code, f, w, cin));
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
        op       = 4'd0;
        f_opnd   = $urandom_range(0, 255);
        w_opnd   = $urandom_range(0, 255);
    endtask

    // Monitor: pops one expected item for each valid output (R2).
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (sb_q.size() == 0) begin
                check("R2 unexpected out_valid", 1, 0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check({e.tag, " result"}, result, e.data);
                check({e.tag, " c_we"},  c_we,  e.cwe);
                check({e.tag, " dc_we"}, dc_we, e.dcwe);
                check({e.tag, " z_we"},  z_we,  e.zwe);
                if (e.cwe)  check({e.tag, " c_out"},  c_out,  e.c);
                if (e.dcwe) check({e.tag, " dc_out"}, dc_out, e.dc);
                if (e.zwe)  check({e.tag, " R5 z_out"}, z_out, e.z);
                last_data = result;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        rst = 1'b1; in_valid = 1'b0; op = 4'd0; f_opnd = 8'h00; w_opnd = 8'h00; c_in = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 out_valid", out_valid, 0);
        check("R1 result", result, 0);
        check("R1 enables", {c_we, dc_we, z_we}, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after reset", {out_valid, c_we, dc_we, z_we}, 0);

        // R3 add corners
        send(0, 8'hFF, 8'h01, 0);
        send(0, 8'h0F, 8'h01, 0);
        send(0, 8'h10, 8'h20, 1);
        send(0, 8'h88, 8'h88, 0);
        // R4 subtract corners
        send(1, 8'h05, 8'h05, 0);
        send(1, 8'h03, 8'h05, 1);
        send(1, 8'h20, 8'h01, 0);
        send(1, 8'h13, 8'h12, 0);
        send(1, 8'h00, 8'hFF, 0);
        // R6 / R7 logic
        send(2, 8'hF0, 8'h0F, 1);
        send(2, 8'hA5, 8'hFF, 1);
        send(3, 8'h00, 8'h00, 1);
        send(3, 8'h50, 8'h0A, 1);
        send(4, 8'h3C, 8'h3C, 1);
        send(5, 8'hFF, 8'h00, 1);
        send(5, 8'h12, 8'h00, 1);
        send(6, 8'h00, 8'h77, 1);
        send(6, 8'h9A, 8'h77, 1);
        // R8 / R9 rotates through carry
        send(7, 8'h80, 8'h00, 0);
        send(7, 8'h41, 8'h00, 1);
        send(8, 8'h01, 8'h00, 0);
        send(8, 8'h82, 8'h00, 1);
        // R10 reserved
        send(9, 8'h55, 8'hAA, 1);
        send(15, 8'hFF, 8'hFF, 1);

        // R11: idle cycle holds result, drops enables
        send(6, 8'h6B, 8'h00, 0);
        idle();
        @(negedge clk);
        check("R11 out_valid", out_valid, 0);
        check("R11 enables", {c_we, dc_we, z_we}, 0);
        check("R11 result held", result, 8'h6B);

        // Mixed stream with random idles
        for (int i = 0; i < 400; i++) begin
            if ($urandom_range(0, 4) == 0) idle();
            else send($urandom_range(0, 15), $urandom_range(0, 255),
                      $urandom_range(0, 255), 1'($urandom_range(0, 1)));
        end
        idle();
        repeat (3) @(negedge clk);
        check("R2 queue drained", sb_q.size(), 0);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule